// File: doc/BRIEF.md
# Nine-Bit Multiprocessor Serial Port

This block is an asynchronous serial port that moves eleven-bit frames: one low start bit, eight data bits with the least significant bit first, a ninth bit chosen per frame, and one high stop bit. A baud tick from outside the block runs at sixteen times the bit rate and times both directions. Writing a byte starts a transmission. The transmit-done flag rises when the stop bit reaches the line.

The receiver waits for a start bit while reception is enabled. It takes each bit from a majority vote near the middle of the bit, and it applies acceptance rules when the ninth bit arrives. A filter can pass only frames whose ninth bit is set, which serves as an address mark on a shared bus. When the extended mode is off, an overrun guard drops a new frame while the previous one is still unread. When the extended mode is on, the new frame replaces the unread one and a sticky overrun flag is set. A dropped frame changes nothing the port exposes.

Top module: `ninebit_uart`

## Requirements
- R1: After reset, txLine is 1, and txDone, rxDone, overrun, rxNinth and rxData are all 0.
- R2: A transmitted frame holds each bit for 16 baud ticks, in this order: start 0, txData bit 0 through bit 7, txNinth, stop 1.
- R3: txLine falls at the first baud tick after a txWrite accepted while idle, and it changes only on the clock edge that follows a baud tick. A txWrite during a frame is ignored, and the frame in flight is not altered.
- R4: txDone goes to 1 on the same edge that drives the stop bit onto txLine. A clrTxDone pulse clears it unless a new set happens in the same cycle, in which case the set wins.
- R5: A start bit is recognised only while rxEnable is 1. A frame sent while rxEnable is 0 leaves rxDone, rxData and rxNinth unchanged.
- R6: Each received bit is the majority of three samples taken at oversample counts 7, 8 and 9. A start bit that votes high is rejected as a glitch, and the receiver returns to waiting for a start bit.
- R7: When a frame is accepted, its 8 data bits go to rxData, its ninth bit goes to rxNinth, and rxDone is set. All three happen at the vote of the ninth bit.
- R8: While addrFilter is 1, a frame whose ninth bit is 0 is discarded. rxData, rxNinth, rxDone and overrun keep their values.
- R9: While extMode is 0, a frame that completes while rxDone is 1 is discarded, and the unread data is kept.
- R10: While extMode is 1, a frame that completes while rxDone is 1 overwrites rxData and rxNinth and sets overrun. overrun stays 1 until a clrRxDone pulse.
- R11: A clrRxDone pulse clears rxDone and overrun on the next edge, unless a frame is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-cycle tick at 16 times the bit rate |
| txWrite | input | 1 | Strobe that loads txData and txNinth and starts a frame |
| txData | input | 8 | Byte to send |
| txNinth | input | 1 | Ninth bit to send |
| clrTxDone | input | 1 | Strobe that clears txDone |
| txLine | output | 1 | Serial output, high when idle |
| txDone | output | 1 | Transmit-done flag |
| rxLine | input | 1 | Serial input |
| rxEnable | input | 1 | Allows detection of a start bit |
| addrFilter | input | 1 | Accept only frames whose ninth bit is 1 |
| extMode | input | 1 | Allow overwrite of unread data and flag overrun |
| clrRxDone | input | 1 | Strobe that clears rxDone and overrun |
| rxData | output | 8 | Last accepted byte |
| rxNinth | output | 1 | Ninth bit of the last accepted frame |
| rxDone | output | 1 | Receive-done flag |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The transmit line moves one clock after a baud tick. With a tick every second clock, every bit lasts 32 clocks, so the bench finds the falling start edge and then samples each bit 16 clocks into it. Each sample falls at the centre of the bit, far from any transition. txDone is due on the same edge as the stop bit, so it is checked as 0 at the centre of the ninth bit and as 1 at the centre of the stop bit. Receive results appear at the vote of the ninth bit, about a bit and a half before the stimulus ends, so the bench checks rxData, rxNinth, rxDone and overrun only after it has driven the full stop bit. Each clear strobe is checked one edge later.

// File: rtl/ninebit_uart_pkg.sv
package ninebit_uart_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic txLoad;     // capture byte and ninth bit
    logic txStart;    // drive the start bit
    logic txShift;    // drive the next bit of the frame
    logic txEnd;      // return the line to idle
    logic txDoneSet;  // stop bit is being driven
    logic rxSample;   // record one vote sample
    logic rxStore;    // shift the voted bit in
    logic rxCommit;   // frame accepted
    logic rxOverrun;  // accepted over unread data
  } uartStrobe_t;

endpackage

// File: rtl/ninebit_uart_ctrl.sv
module ninebit_uart_ctrl
  import ninebit_uart_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        baudTick,
  input  logic        txWrite,
  input  logic        rxEnable,
  input  logic        addrFilter,
  input  logic        extMode,
  input  logic        rxSync,
  input  logic        voteBit,
  input  logic        rxDoneQ,
  output uartStrobe_t stb
);
  localparam int CNT_W      = $clog2(OVERSAMPLE);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int BIT_W      = $clog2(FRAME_BITS + 1);
  localparam int MID        = OVERSAMPLE / 2;
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] BIT_NINTH = BIT_W'(DATA_W + 1);
  localparam logic [BIT_W-1:0] BIT_STOP  = BIT_W'(DATA_W + 2);

  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_RUN} txState_t;
  typedef enum logic {RX_IDLE, RX_RUN} rxState_t;

  txState_t txState, txStateNext;
  rxState_t rxState, rxStateNext;
  logic [CNT_W-1:0] txCnt, txCntNext, rxCnt, rxCntNext;
  logic [BIT_W-1:0] txBit, txBitNext, rxBit, rxBitNext;
  logic accept;

  // Transmit sequencer
  always_comb begin
    txStateNext = txState;
    txCntNext   = txCnt;
    txBitNext   = txBit;
    stb.txLoad    = 1'b0;
    stb.txStart   = 1'b0;
    stb.txShift   = 1'b0;
    stb.txEnd     = 1'b0;
    stb.txDoneSet = 1'b0;
    case (txState)
      TX_IDLE: if (txWrite) begin
        stb.txLoad  = 1'b1;
        txStateNext = TX_WAIT;
      end
      TX_WAIT: if (baudTick) begin
        stb.txStart = 1'b1;
        txCntNext   = '0;
        txBitNext   = '0;
        txStateNext = TX_RUN;
      end
      default: if (baudTick) begin
        if (txCnt == CNT_LAST) begin
          txCntNext = '0;
          if (txBit == BIT_STOP) begin
            stb.txEnd   = 1'b1;
            txStateNext = TX_IDLE;
          end else begin
            stb.txShift   = 1'b1;
            stb.txDoneSet = (txBit == BIT_NINTH);
            txBitNext     = txBit + 1'b1;
          end
        end else begin
          txCntNext = txCnt + 1'b1;
        end
      end
    endcase
  end

  // Receive sequencer
  assign accept = (extMode || !rxDoneQ) && (!addrFilter || voteBit);

  always_comb begin
    rxStateNext = rxState;
    rxCntNext   = rxCnt;
    rxBitNext   = rxBit;
    stb.rxSample  = 1'b0;
    stb.rxStore   = 1'b0;
    stb.rxCommit  = 1'b0;
    stb.rxOverrun = 1'b0;
    if (baudTick) begin
      if (rxState == RX_IDLE) begin
        if (rxEnable && !rxSync) begin
          rxStateNext = RX_RUN;
          rxCntNext   = '0;
          rxBitNext   = '0;
        end
      end else begin
        rxCntNext = (rxCnt == CNT_LAST) ? '0 : rxCnt + 1'b1;
        if (rxCnt == CNT_LAST) rxBitNext = rxBit + 1'b1;
        if (rxCnt == CNT_W'(MID - 1) || rxCnt == CNT_W'(MID)) stb.rxSample = 1'b1;
        if (rxCnt == CNT_W'(MID + 1)) begin
          if (rxBit == '0) begin
            if (voteBit) rxStateNext = RX_IDLE;
          end else if (rxBit == BIT_STOP) begin
            rxStateNext = RX_IDLE;
          end else begin
            stb.rxStore = 1'b1;
            if (rxBit == BIT_NINTH) begin
              stb.rxCommit  = accept;
              stb.rxOverrun = accept && rxDoneQ;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      rxState <= RX_IDLE;
      txCnt   <= '0;
      rxCnt   <= '0;
      txBit   <= '0;
      rxBit   <= '0;
    end else begin
      txState <= txStateNext;
      rxState <= rxStateNext;
      txCnt   <= txCntNext;
      rxCnt   <= rxCntNext;
      txBit   <= txBitNext;
      rxBit   <= rxBitNext;
    end
  end
endmodule

// File: rtl/ninebit_uart_dp.sv
module ninebit_uart_dp
  import ninebit_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  uartStrobe_t       stb,
  input  logic [DATA_W-1:0] txData,
  input  logic              txNinth,
  input  logic              clrTxDone,
  input  logic              clrRxDone,
  input  logic              rxLine,
  output logic              txLine,
  output logic              txDone,
  output logic              rxSync,
  output logic              voteBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              rxDone,
  output logic              overrun
);
  localparam int TX_W = DATA_W + 2;
  localparam int RX_W = DATA_W + 1;

  logic [TX_W-1:0] txShiftReg;
  logic [RX_W-1:0] rxShiftReg, rxShiftNext;
  logic [1:0]      syncReg;
  logic [1:0]      sampleWin;

  assign rxSync  = syncReg[1];
  assign voteBit = (sampleWin[0] & sampleWin[1]) | (sampleWin[0] & rxSync) |
                   (sampleWin[1] & rxSync);
  assign rxShiftNext = {voteBit, rxShiftReg[RX_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShiftReg <= '1;
      txLine     <= 1'b1;
      txDone     <= 1'b0;
      syncReg    <= 2'b11;
      sampleWin  <= 2'b11;
      rxShiftReg <= '0;
      rxData     <= '0;
      rxNinth    <= 1'b0;
      rxDone     <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      syncReg <= {syncReg[0], rxLine};
      // transmit path
      if (stb.txLoad) txShiftReg <= {1'b1, txNinth, txData};
      if (stb.txStart) txLine <= 1'b0;
      if (stb.txShift) begin
        txLine     <= txShiftReg[0];
        txShiftReg <= {1'b1, txShiftReg[TX_W-1:1]};
      end
      if (stb.txEnd) txLine <= 1'b1;
      if (stb.txDoneSet) txDone <= 1'b1;
      else if (clrTxDone) txDone <= 1'b0;
      // receive path
      if (stb.rxSample) sampleWin <= {sampleWin[0], rxSync};
      if (stb.rxStore) rxShiftReg <= rxShiftNext;
      if (stb.rxCommit) begin
        rxData  <= rxShiftNext[DATA_W-1:0];
        rxNinth <= voteBit;
      end
      if (stb.rxCommit) rxDone <= 1'b1;
      else if (clrRxDone) rxDone <= 1'b0;
      if (stb.rxOverrun) overrun <= 1'b1;
      else if (clrRxDone) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/ninebit_uart.sv
module ninebit_uart
  import ninebit_uart_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              txNinth,
  input  logic              clrTxDone,
  output logic              txLine,
  output logic              txDone,
  input  logic              rxLine,
  input  logic              rxEnable,
  input  logic              addrFilter,
  input  logic              extMode,
  input  logic              clrRxDone,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              rxDone,
  output logic              overrun
);
  uartStrobe_t stb;
  logic rxSync, voteBit;

  ninebit_uart_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txWrite(txWrite),
    .rxEnable(rxEnable), .addrFilter(addrFilter), .extMode(extMode),
    .rxSync(rxSync), .voteBit(voteBit), .rxDoneQ(rxDone), .stb(stb)
  );

  ninebit_uart_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txData(txData), .txNinth(txNinth),
    .clrTxDone(clrTxDone), .clrRxDone(clrRxDone), .rxLine(rxLine),
    .txLine(txLine), .txDone(txDone), .rxSync(rxSync), .voteBit(voteBit),
    .rxData(rxData), .rxNinth(rxNinth), .rxDone(rxDone), .overrun(overrun)
  );
endmodule

// File: rtl/ninebit_uart_chk.sv
module ninebit_uart_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              baudTick,
  input logic              txLine,
  input logic              txDone,
  input logic              clrTxDone,
  input logic              txDoneSet,
  input logic [DATA_W-1:0] rxData,
  input logic              rxNinth,
  input logic              rxDone,
  input logic              clrRxDone,
  input logic              rxCommit,
  input logic              addrFilter,
  input logic              extMode,
  input logic              overrun
);
  p_line_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txLine) |-> $past(baudTick));

  p_done_with_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> txLine);

  p_tx_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clrTxDone && !txDoneSet) |=> !txDone);

  p_data_with_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(rxData) || !$stable(rxNinth)) |-> rxDone);

  p_filter_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) |-> (!$past(addrFilter) || rxNinth));

  p_overrun_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> ($past(extMode) && $past(rxDone)));

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !clrRxDone) |=> overrun);

  p_rx_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (clrRxDone && !rxCommit) |=> (!rxDone && !overrun));
endmodule

bind ninebit_uart ninebit_uart_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .txLine(txLine),
  .txDone(txDone), .clrTxDone(clrTxDone), .txDoneSet(stb.txDoneSet),
  .rxData(rxData), .rxNinth(rxNinth), .rxDone(rxDone), .clrRxDone(clrRxDone),
  .rxCommit(stb.rxCommit), .addrFilter(addrFilter), .extMode(extMode),
  .overrun(overrun)
);

// File: tb/sim_ninebit_uart.sv
`timescale 1ns/1ps
module sim_ninebit_uart;
  localparam int BIT_CLKS = 32;   // 16 ticks, one tick every 2 clocks

  logic clk = 1'b0, rstN = 1'b0, baudTick = 1'b0;
  logic txWrite = 1'b0, txNinth = 1'b0, clrTxDone = 1'b0, clrRxDone = 1'b0;
  logic [7:0] txData = '0;
  logic rxLine = 1'b1, rxEnable = 1'b0, addrFilter = 1'b0, extMode = 1'b0;
  logic txLine, txDone, rxNinth, rxDone, overrun;
  logic [7:0] rxData;

  int checks = 0, fails = 0;
  logic mDone = 1'b0, mNinth = 1'b0, mOvr = 1'b0;
  logic [7:0] mData = '0;

  always #5 clk = ~clk;
  always @(negedge clk) if (rstN) baudTick <= ~baudTick;

  ninebit_uart u0 (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txWrite(txWrite),
    .txData(txData), .txNinth(txNinth), .clrTxDone(clrTxDone),
    .txLine(txLine), .txDone(txDone), .rxLine(rxLine), .rxEnable(rxEnable),
    .addrFilter(addrFilter), .extMode(extMode), .clrRxDone(clrRxDone),
    .rxData(rxData), .rxNinth(rxNinth), .rxDone(rxDone), .overrun(overrun)
  );

  // {data, ninth, filter, ext, clear-before}
  localparam logic [11:0] VEC [8] = '{
    {8'hA5, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h3C, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h77, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'h81, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h5A, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendRx(input logic [7:0] d, input logic n9);
    logic [10:0] fr;
    fr = {1'b1, n9, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxLine = fr[i];
      waitClk(BIT_CLKS);
    end
    waitClk(8);
  endtask

  task automatic pulseClrRx();
    clrRxDone = 1'b1; waitClk(1); clrRxDone = 1'b0;
    mDone = 1'b0; mOvr = 1'b0;
    check(rxDone == 1'b0 && overrun == 1'b0, "R11 clear", {rxDone, overrun}, 0);
  endtask

  task automatic checkRx(input string req);
    check(rxDone == mDone, {req, " rxDone"}, rxDone, mDone);
    check(rxData == mData, {req, " rxData"}, rxData, mData);
    check(rxNinth == mNinth, {req, " rxNinth"}, rxNinth, mNinth);
    check(overrun == mOvr, {req, " overrun"}, overrun, mOvr);
  endtask

  task automatic sendTx(input logic [7:0] d, input logic n9);
    logic [10:0] fr;
    int lat;
    fr = {1'b1, n9, d, 1'b0};
    clrTxDone = 1'b1; waitClk(1); clrTxDone = 1'b0;
    check(txDone == 1'b0, "R4 clear", txDone, 0);
    txData = d; txNinth = n9; txWrite = 1'b1; waitClk(1); txWrite = 1'b0;
    lat = 1;
    while (txLine == 1'b1 && lat < 20) begin waitClk(1); lat++; end
    check(lat <= 4, "R3 start latency", lat, 4);
    waitClk(BIT_CLKS / 2);
    // a write mid-frame must not disturb the frame (R3)
    txData = ~d; txNinth = ~n9; txWrite = 1'b1; waitClk(1); txWrite = 1'b0;
    waitClk(-1 + 1);
    for (int i = 0; i < 11; i++) begin
      if (i > 0) waitClk(BIT_CLKS);
      else waitClk(0);
      check(txLine == fr[i], "R2 tx bit", txLine, fr[i]);
      if (i == 9) check(txDone == 1'b0, "R4 early", txDone, 0);
      if (i == 10) check(txDone == 1'b1, "R4 at stop", txDone, 1);
    end
    waitClk(BIT_CLKS);
  endtask

  initial begin
    logic acc;
    waitClk(3);
    // R1: reset state
    check(txLine == 1'b1, "R1 txLine", txLine, 1);
    check({txDone, rxDone, overrun, rxNinth} == 4'b0, "R1 flags",
          {txDone, rxDone, overrun, rxNinth}, 0);
    check(rxData == 8'h00, "R1 rxData", rxData, 0);
    rstN = 1'b1;
    waitClk(4);

    // R5: receiver disabled
    sendRx(8'h99, 1'b1);
    checkRx("R5 disabled");
    rxEnable = 1'b1;

    // Vector walk: R2 R3 R4 on transmit, R7 R8 R9 R10 on receive
    foreach (VEC[k]) begin
      sendTx(VEC[k][11:4], VEC[k][3]);
      if (VEC[k][0]) pulseClrRx();
      addrFilter = VEC[k][2]; extMode = VEC[k][1];
      sendRx(VEC[k][11:4], VEC[k][3]);
      acc = (extMode || !mDone) && (!addrFilter || VEC[k][3]);
      if (acc) begin
        if (mDone) mOvr = 1'b1;
        mDone = 1'b1; mData = VEC[k][11:4]; mNinth = VEC[k][3];
      end
      checkRx("R7 R8 R9 R10 vector");
    end

    // R6: glitch shorter than half a bit is rejected
    pulseClrRx();
    addrFilter = 1'b0; extMode = 1'b0;
    rxLine = 1'b0; waitClk(8); rxLine = 1'b1; waitClk(3 * BIT_CLKS);
    checkRx("R6 glitch");
    sendRx(8'hC3, 1'b0);
    mDone = 1'b1; mData = 8'hC3; mNinth = 1'b0;
    checkRx("R6 after glitch");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    waitClk(200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule